// File: doc/BRIEF.md
# Floppy DMA register window

This block is the processor-side register window placed in front of a floppy-disk controller and its DMA sector counter. A 16-bit steering register, reached at its own address, decides which internal register a single shared 16-bit data port reaches. Through that port the processor reaches one of six registers: the DMA sector count, the DMA control word, or one of four disk-controller registers (command/status, track, sector, data).

Writing the command register latches the command word and sends a one-cycle start pulse to the disk controller. The block also holds a read-only DMA status word. It drives an active-low disk-interrupt line. The line falls while the controller raises its interrupt, and returns high when software reads the controller status after the interrupt has cleared. Three separate byte registers hold the DMA address. Every access to the shared data port asks the bus for extra wait cycles.

Bus accesses last one cycle. A write is taken at the rising clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from the address and the steering register.

Top module: `fdma_regwin`

## Requirements
- R1: With steering bit 4 set, the shared data port (address 0) reads and writes the DMA sector count, whatever bit 3 holds; its value appears on `dma_seccnt_o`.
- R2: With steering bit 4 clear and bit 3 set, the shared data port reads and writes the DMA control word, visible on `dma_ctl_o`.
- R3: With steering bits 4 and 3 clear, steering bits 2:1 pick the controller register: 0 = command on write and `fdc_status_i` on read, 1 = track, 2 = sector, 3 = data. Track, sector and data read back what was written, and are driven on `fdc_track_o`, `fdc_sector_o` and `fdc_data_o`.
- R4: A write to the command register stores the word on `fdc_cmd_o` and raises `fdc_cmd_start` for exactly the one cycle after the write edge. No other write raises it.
- R5: While `fdc_irq_i` is high, `dsk_int_n` is driven low from the next edge on. A status read (data port, steering bits 4:1 all zero) taken while `fdc_irq_i` is low drives `dsk_int_n` high at that edge. No other access changes the line.
- R6: The DMA status word at address 2 reads 0x0001 (DMA ready) after reset, and writes to it are ignored.
- R7: `bus_wait` is 4 during every access to the shared data port and 0 for every other access and when idle.
- R8: The DMA address bytes at addresses 3 (low), 4 (middle) and 5 (high) are written from `bus_wdata[7:0]` and read back zero-extended, each independently of the others. They form `dma_addr_o` high:middle:low.
- R9: The steering register is read and written at address 1. Reset clears every register except the DMA status word and leaves `dsk_int_n` high. Reads of unmapped addresses 6 and 7 return 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| bus_wait | output | 3 | Wait cycles requested for the current access |
| fdc_status_i | input | 16 | Controller status word |
| fdc_irq_i | input | 1 | Controller interrupt, active high |
| fdc_cmd_start | output | 1 | One-cycle command start pulse |
| fdc_cmd_o | output | 16 | Stored command word |
| fdc_track_o | output | 16 | Track register |
| fdc_sector_o | output | 16 | Sector register |
| fdc_data_o | output | 16 | Data register |
| dma_seccnt_o | output | 16 | DMA sector count |
| dma_ctl_o | output | 16 | DMA control word |
| dma_addr_o | output | 24 | DMA address, high:middle:low bytes |
| dsk_int_n | output | 1 | Disk interrupt, active low |

## Verification
The assertions check on every cycle the behaviour that depends only on the access being made. That covers the wait count on shared-port accesses, the constant DMA status word, and the width and contents of the command pulse. It also covers the interrupt line falling under a controller interrupt and rising after a clean status read, and data-port reads agreeing with the sector-count and control outputs under their steering bits. The bench scenarios show what needs history: the bit 4 over bit 3 priority with both set, and registers keeping their values across writes aimed elsewhere. They also show independent updates of the address bytes, ignored status writes, a track read that leaves the interrupt line low, and the values seen just after reset.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

    localparam int DW      = 16;
    localparam int BW      = 8;
    localparam int AW      = 3;
    localparam int NBYTE   = 3;

    localparam logic [AW-1:0] ADR_DATA = 3'd0;
    localparam logic [AW-1:0] ADR_MODE = 3'd1;
    localparam logic [AW-1:0] ADR_STAT = 3'd2;
    localparam logic [AW-1:0] ADR_DADR = 3'd3;

    localparam int MODE_SC_BIT  = 4;
    localparam int MODE_CTL_BIT = 3;
    localparam int MODE_FSEL_LO = 1;

    localparam logic [DW-1:0] STAT_READY = 16'h0001;
    localparam logic [DW-1:0] OPEN_BUS   = 16'hFFFF;

    typedef enum logic [2:0] {
        TGT_SECCNT  = 3'd0,
        TGT_DMACTL  = 3'd1,
        TGT_CMDSTAT = 3'd2,
        TGT_TRACK   = 3'd3,
        TGT_SECTOR  = 3'd4,
        TGT_DATA    = 3'd5
    } port_tgt_e;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [AW-1:0] adr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic             data;
        logic             mode;
        logic             stat;
        logic [NBYTE-1:0] dadr;
    } sel_t;

    typedef struct packed {
        logic [DW-1:0] mode;
        logic [DW-1:0] seccnt;
        logic [DW-1:0] dmactl;
        logic [DW-1:0] cmd;
        logic [DW-1:0] track;
        logic [DW-1:0] sector;
        logic [DW-1:0] data;
        logic [DW-1:0] stat;
    } regs_t;

    function automatic port_tgt_e steer(input logic [DW-1:0] mode);
        port_tgt_e t;
        if (mode[MODE_SC_BIT]) begin
            t = TGT_SECCNT;
        end else if (mode[MODE_CTL_BIT]) begin
            t = TGT_DMACTL;
        end else begin
            unique case (mode[MODE_FSEL_LO +: 2])
                2'd0:    t = TGT_CMDSTAT;
                2'd1:    t = TGT_TRACK;
                2'd2:    t = TGT_SECTOR;
                default: t = TGT_DATA;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/fdma_decode.sv
module fdma_decode
    import fdma_pkg::*;
#(
    parameter int WAIT_CYC = 4,
    localparam int WAIT_W  = $clog2(WAIT_CYC + 1)
) (
    input  bus_req_t          req,
    input  logic [DW-1:0]     mode,
    output sel_t              sel,
    output port_tgt_e         tgt,
    output logic [WAIT_W-1:0] wait_cyc
);

    logic active;

    assign active = req.rd | req.wr;
    assign tgt    = steer(mode);

    always_comb begin
        sel      = '0;
        sel.data = active && (req.adr == ADR_DATA);
        sel.mode = active && (req.adr == ADR_MODE);
        sel.stat = active && (req.adr == ADR_STAT);
        for (int i = 0; i < NBYTE; i++) begin
            sel.dadr[i] = active && (req.adr == ADR_DADR + AW'(i));
        end
    end

    assign wait_cyc = sel.data ? WAIT_W'(WAIT_CYC) : '0;

endmodule

// File: rtl/fdma_regfile.sv
module fdma_regfile
    import fdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_req_t  req,
    input  sel_t      sel,
    input  port_tgt_e tgt,
    output regs_t     regs,
    output logic      cmd_start
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs      <= '0;
            regs.stat <= STAT_READY;
            cmd_start <= 1'b0;
        end else begin
            cmd_start <= 1'b0;
            if (req.wr && sel.mode) begin
                regs.mode <= req.wdata;
            end
            if (req.wr && sel.data) begin
                unique case (tgt)
                    TGT_SECCNT:  regs.seccnt <= req.wdata;
                    TGT_DMACTL:  regs.dmactl <= req.wdata;
                    TGT_CMDSTAT: begin
                        regs.cmd  <= req.wdata;
                        cmd_start <= 1'b1;
                    end
                    TGT_TRACK:   regs.track  <= req.wdata;
                    TGT_SECTOR:  regs.sector <= req.wdata;
                    TGT_DATA:    regs.data   <= req.wdata;
                    default:     ;
                endcase
            end
        end
    end

endmodule

// File: rtl/fdma_bytereg.sv
module fdma_bytereg
    import fdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [BW-1:0] d,
    output logic [BW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/fdma_intline.sv
module fdma_intline (
    input  logic clk,
    input  logic rst,
    input  logic irq,
    input  logic status_rd,
    output logic int_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            int_n <= 1'b1;
        end else if (irq) begin
            int_n <= 1'b0;
        end else if (status_rd) begin
            int_n <= 1'b1;
        end
    end

endmodule

// File: rtl/fdma_regwin.sv
module fdma_regwin
    import fdma_pkg::*;
#(
    parameter int WAIT_CYC = 4,
    localparam int WAIT_W  = $clog2(WAIT_CYC + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic [WAIT_W-1:0]   bus_wait,
    input  logic [DW-1:0]       fdc_status_i,
    input  logic                fdc_irq_i,
    output logic                fdc_cmd_start,
    output logic [DW-1:0]       fdc_cmd_o,
    output logic [DW-1:0]       fdc_track_o,
    output logic [DW-1:0]       fdc_sector_o,
    output logic [DW-1:0]       fdc_data_o,
    output logic [DW-1:0]       dma_seccnt_o,
    output logic [DW-1:0]       dma_ctl_o,
    output logic [NBYTE*BW-1:0] dma_addr_o,
    output logic                dsk_int_n
);

    bus_req_t      req;
    sel_t          sel;
    port_tgt_e     tgt;
    regs_t         regs;
    logic [DW-1:0] mode_q;
    logic [BW-1:0] dadr_q [NBYTE];
    logic          status_rd;

    assign req.rd    = bus_sel & ~bus_we;
    assign req.wr    = bus_sel &  bus_we;
    assign req.adr   = bus_addr;
    assign req.wdata = bus_wdata;
    assign mode_q    = regs.mode;

    fdma_decode #(.WAIT_CYC(WAIT_CYC)) u_decode (
        .req      (req),
        .mode     (mode_q),
        .sel      (sel),
        .tgt      (tgt),
        .wait_cyc (bus_wait)
    );

    fdma_regfile u_regfile (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .sel       (sel),
        .tgt       (tgt),
        .regs      (regs),
        .cmd_start (fdc_cmd_start)
    );

    for (genvar i = 0; i < NBYTE; i++) begin : g_dadr
        fdma_bytereg u_byte (
            .clk (clk),
            .rst (rst),
            .we  (req.wr & sel.dadr[i]),
            .d   (bus_wdata[BW-1:0]),
            .q   (dadr_q[i])
        );
        assign dma_addr_o[i*BW +: BW] = dadr_q[i];
    end

    assign status_rd = req.rd && sel.data && (tgt == TGT_CMDSTAT);

    fdma_intline u_intline (
        .clk       (clk),
        .rst       (rst),
        .irq       (fdc_irq_i),
        .status_rd (status_rd),
        .int_n     (dsk_int_n)
    );

    always_comb begin
        bus_rdata = OPEN_BUS;
        if (sel.data) begin
            unique case (tgt)
                TGT_SECCNT:  bus_rdata = regs.seccnt;
                TGT_DMACTL:  bus_rdata = regs.dmactl;
                TGT_CMDSTAT: bus_rdata = fdc_status_i;
                TGT_TRACK:   bus_rdata = regs.track;
                TGT_SECTOR:  bus_rdata = regs.sector;
                TGT_DATA:    bus_rdata = regs.data;
                default:     bus_rdata = OPEN_BUS;
            endcase
        end else if (sel.mode) begin
            bus_rdata = regs.mode;
        end else if (sel.stat) begin
            bus_rdata = regs.stat;
        end else begin
            for (int i = 0; i < NBYTE; i++) begin
                if (sel.dadr[i]) begin
                    bus_rdata = {{(DW-BW){1'b0}}, dadr_q[i]};
                end
            end
        end
    end

    assign fdc_cmd_o    = regs.cmd;
    assign fdc_track_o  = regs.track;
    assign fdc_sector_o = regs.sector;
    assign fdc_data_o   = regs.data;
    assign dma_seccnt_o = regs.seccnt;
    assign dma_ctl_o    = regs.dmactl;

endmodule

// File: rtl/fdma_regwin_chk.sv
module fdma_regwin_chk
    import fdma_pkg::*;
#(
    parameter int WAIT_CYC = 4,
    localparam int WAIT_W  = $clog2(WAIT_CYC + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [WAIT_W-1:0] bus_wait,
    input logic              fdc_irq_i,
    input logic              fdc_cmd_start,
    input logic [DW-1:0]     fdc_cmd_o,
    input logic [DW-1:0]     dma_seccnt_o,
    input logic [DW-1:0]     dma_ctl_o,
    input logic              dsk_int_n,
    input logic [DW-1:0]     mode_q
);

    logic port_rd, port_wr, cmd_mode;

    assign port_rd  = bus_sel && !bus_we && (bus_addr == ADR_DATA);
    assign port_wr  = bus_sel &&  bus_we && (bus_addr == ADR_DATA);
    assign cmd_mode = (mode_q[4:1] == 4'b0000);

    AST_SECCNT_READ: assert property (@(posedge clk) disable iff (rst)
        (port_rd && mode_q[4]) |-> (bus_rdata == dma_seccnt_o)); // R1

    AST_DMACTL_READ: assert property (@(posedge clk) disable iff (rst)
        (port_rd && !mode_q[4] && mode_q[3]) |-> (bus_rdata == dma_ctl_o)); // R2

    AST_CMD_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
        fdc_cmd_start |-> $past(port_wr && cmd_mode)); // R4

    AST_CMD_PULSE_VALUE: assert property (@(posedge clk) disable iff (rst)
        fdc_cmd_start |-> (fdc_cmd_o == $past(bus_wdata))); // R4

    AST_CMD_PULSE_FIRES: assert property (@(posedge clk) disable iff (rst)
        (port_wr && cmd_mode) |=> fdc_cmd_start); // R4

    AST_INT_ASSERT: assert property (@(posedge clk) disable iff (rst)
        fdc_irq_i |=> !dsk_int_n); // R5

    AST_INT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (port_rd && cmd_mode && !fdc_irq_i) |=> dsk_int_n); // R5

    AST_STATUS_CONST: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == ADR_STAT) |-> (bus_rdata == STAT_READY)); // R6

    AST_WAIT_PORT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr == ADR_DATA) |-> (bus_wait == WAIT_W'(WAIT_CYC))); // R7

    AST_WAIT_OTHER: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_addr == ADR_DATA) |-> (bus_wait == '0)); // R7

endmodule

bind fdma_regwin fdma_regwin_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_wait      (bus_wait),
    .fdc_irq_i     (fdc_irq_i),
    .fdc_cmd_start (fdc_cmd_start),
    .fdc_cmd_o     (fdc_cmd_o),
    .dma_seccnt_o  (dma_seccnt_o),
    .dma_ctl_o     (dma_ctl_o),
    .dsk_int_n     (dsk_int_n),
    .mode_q        (mode_q)
);

// File: tb/fdma_regwin_bench.sv
module fdma_regwin_bench;
    import fdma_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [2:0]    bus_wait;
    logic [15:0]   fdc_status_i = '0;
    logic          fdc_irq_i = 1'b0;
    logic          fdc_cmd_start;
    logic [15:0]   fdc_cmd_o, fdc_track_o, fdc_sector_o, fdc_data_o;
    logic [15:0]   dma_seccnt_o, dma_ctl_o;
    logic [23:0]   dma_addr_o;
    logic          dsk_int_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] d;
        logic [2:0]  w;
        bit          cd;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    fdma_regwin u_fdma_regwin (
        .clk (clk), .rst (rst),
        .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_wait (bus_wait),
        .fdc_status_i (fdc_status_i), .fdc_irq_i (fdc_irq_i),
        .fdc_cmd_start (fdc_cmd_start), .fdc_cmd_o (fdc_cmd_o),
        .fdc_track_o (fdc_track_o), .fdc_sector_o (fdc_sector_o),
        .fdc_data_o (fdc_data_o), .dma_seccnt_o (dma_seccnt_o),
        .dma_ctl_o (dma_ctl_o), .dma_addr_o (dma_addr_o),
        .dsk_int_n (dsk_int_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops one expectation per access, mid-cycle
    always @(negedge clk) begin
        if (!rst && bus_sel && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({"R7 wait ", e.tag}, 32'(bus_wait), 32'(e.w));
            if (e.cd) check(e.tag, 32'(bus_rdata), 32'(e.d));
        end
    end

    task automatic acc(input bit we, input logic [2:0] a, input logic [15:0] d,
                       input logic [15:0] ed, input bit cd, input string tag);
        exp_t e;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        e.d = ed; e.w = (a == ADR_DATA) ? 3'd4 : 3'd0; e.cd = cd; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        acc(1'b1, a, d, 16'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
        acc(1'b0, a, 16'h0, e, 1'b1, tag);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R9 reset state
        rd(ADR_MODE, 16'h0000, "R9 mode after reset");
        rd(3'd5, 16'h0000, "R9 addr byte after reset");
        check("R9 int line after reset", 32'(dsk_int_n), 32'd1);
        check("R9 seccnt after reset", 32'(dma_seccnt_o), 32'd0);
        rd(3'd6, 16'hFFFF, "R9 unmapped 6");
        rd(3'd7, 16'hFFFF, "R9 unmapped 7");

        // R6 status word
        rd(ADR_STAT, 16'h0001, "R6 status ready");
        wr(ADR_STAT, 16'hABCD, "R6 status write");
        rd(ADR_STAT, 16'h0001, "R6 status write ignored");

        // R1 sector count
        wr(ADR_MODE, 16'h0010, "R9 mode write");
        rd(ADR_MODE, 16'h0010, "R9 mode readback");
        wr(ADR_DATA, 16'h1234, "R1 seccnt write");
        rd(ADR_DATA, 16'h1234, "R1 seccnt read");
        check("R1 seccnt output", 32'(dma_seccnt_o), 32'h1234);
        wr(ADR_MODE, 16'h0018, "R1 both bits");
        wr(ADR_DATA, 16'h5555, "R1 priority write");
        rd(ADR_DATA, 16'h5555, "R1 priority read");
        check("R1 ctl untouched", 32'(dma_ctl_o), 32'h0);

        // R2 control
        wr(ADR_MODE, 16'h0008, "R2 mode");
        wr(ADR_DATA, 16'h00A5, "R2 ctl write");
        rd(ADR_DATA, 16'h00A5, "R2 ctl read");
        check("R2 ctl output", 32'(dma_ctl_o), 32'h00A5);
        check("R2 seccnt kept", 32'(dma_seccnt_o), 32'h5555);

        // R3 track / sector / data
        wr(ADR_MODE, 16'h0002, "R3 mode track");
        wr(ADR_DATA, 16'h0011, "R3 track write");
        check("R4 no pulse on track write", 32'(fdc_cmd_start), 32'd0);
        wr(ADR_MODE, 16'h0004, "R3 mode sector");
        wr(ADR_DATA, 16'h0022, "R3 sector write");
        wr(ADR_MODE, 16'h0006, "R3 mode data");
        wr(ADR_DATA, 16'h0033, "R3 data write");
        rd(ADR_DATA, 16'h0033, "R3 data read");
        wr(ADR_MODE, 16'h0002, "R3 mode track");
        rd(ADR_DATA, 16'h0011, "R3 track read");
        wr(ADR_MODE, 16'h0004, "R3 mode sector");
        rd(ADR_DATA, 16'h0022, "R3 sector read");
        check("R3 track out", 32'(fdc_track_o), 32'h0011);
        check("R3 sector out", 32'(fdc_sector_o), 32'h0022);
        check("R3 data out", 32'(fdc_data_o), 32'h0033);

        // R4 command strobe, R3 status read
        wr(ADR_MODE, 16'h0000, "R4 mode cmd");
        fdc_status_i = 16'h0081;
        wr(ADR_DATA, 16'h00F0, "R4 cmd write");
        check("R4 pulse high", 32'(fdc_cmd_start), 32'd1);
        check("R4 cmd value", 32'(fdc_cmd_o), 32'h00F0);
        @(posedge clk); #1;
        check("R4 pulse one cycle", 32'(fdc_cmd_start), 32'd0);
        rd(ADR_DATA, 16'h0081, "R3 status read");
        check("R3 track kept", 32'(fdc_track_o), 32'h0011);

        // R5 interrupt line
        fdc_irq_i = 1'b1;
        @(posedge clk); #1;
        check("R5 line low on irq", 32'(dsk_int_n), 32'd0);
        rd(ADR_DATA, 16'h0081, "R5 status read irq high");
        check("R5 stays low while irq", 32'(dsk_int_n), 32'd0);
        fdc_irq_i = 1'b0;
        wr(ADR_MODE, 16'h0002, "R5 mode track");
        rd(ADR_DATA, 16'h0011, "R5 track read");
        check("R5 track read keeps low", 32'(dsk_int_n), 32'd0);
        wr(ADR_MODE, 16'h0000, "R5 mode cmd");
        check("R5 mode write keeps low", 32'(dsk_int_n), 32'd0);
        rd(ADR_DATA, 16'h0081, "R5 status read clean");
        check("R5 released", 32'(dsk_int_n), 32'd1);

        // R8 address bytes
        wr(3'd5, 16'h0012, "R8 high");
        wr(3'd4, 16'h0034, "R8 mid");
        wr(3'd3, 16'h0056, "R8 low");
        check("R8 address", dma_addr_o, 32'h123456);
        wr(3'd4, 16'hABFF, "R8 mid again");
        rd(3'd4, 16'h00FF, "R8 mid read");
        rd(3'd5, 16'h0012, "R8 high kept");
        rd(3'd3, 16'h0056, "R8 low kept");
        check("R8 address updated", dma_addr_o, 32'h12FF56);

        @(posedge clk); #1;
        done = 1'b1;
        finish_run();
    end

endmodule